// File: doc/BRIEF.md
# Reference Divider with Dual Tap Select

This block divides an incoming reference clock by a programmable ratio and then halves that rate repeatedly in a binary post-stage. The result is five comparison pulse trains, at periods of R, 2R, 4R, 8R and 16R reference cycles. One shared chain serves two phase-locked loops. A main loop and an auxiliary loop each pick their own train through a separate 3-bit code. The two code orders run in opposite directions. Each selected train leaves the block as a one-cycle pulse at the end of its period.

Bringing the block out of power-down restarts the whole chain from a zero phase. This gives the phase comparators a known alignment. While powered down, both outputs stay low and the chain is held cleared.

Top module: `refdiv_top`

## Requirements
- R1: The ratio input `ratio` is 10 bits. For any value from 4 to 1023, the period-R train pulses once every `ratio` reference clock cycles.
- R2: A `ratio` value of 0, 1, 2 or 3 behaves exactly as a value of 4.
- R3: The post-stage provides trains with periods R, 2R, 4R, 8R and 16R, numbered tap 0 to tap 4. Every tap is phase-aligned to the end of a period-R interval.
- R4: On `main_sel`, code n (0 to 4) routes tap n to `main_pulse`. Code 000 gives period R and code 100 gives period 16R.
- R5: On `aux_sel`, code n (0 to 4) routes tap 4−n to `aux_pulse`. Code 100 gives period R and code 000 gives period 16R.
- R6: Codes 101, 110 and 111 on either select act as code 100.
- R7: Each output pulse lasts one clock cycle. After power-up or reset release, the first pulse of a train of period P is visible right after the P-th rising edge at which `enable` is high.
- R8: While `enable` is low, both outputs are low and the chain is held cleared. Raising `enable` restarts every train from zero phase.
- R9: While `rst_n` is low, both outputs are low.
- R10: The two selects work independently. When both select the same tap, the two outputs are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High to run the chain, low for power-down |
| ratio | input | 10 | Programmable first-stage ratio |
| main_sel | input | 3 | Tap code for the main comparator |
| aux_sel | input | 3 | Tap code for the auxiliary comparator (reversed order) |
| main_pulse | output | 1 | Selected pulse train for the main loop |
| aux_pulse | output | 1 | Selected pulse train for the auxiliary loop |

## Verification
The bench measures the cycle of the first pulse and the gap to the second pulse on both outputs. This catches an off-by-one in the terminal count, which would stretch or shrink every period, and a post-stage that counts on the wrong edge, which would shift the higher taps. Ratios below four and the out-of-range select codes are driven directly. Without the clamp, the period would come out wrong. If either code order were mirrored, the main and auxiliary outputs would show swapped periods. A power-down in the middle of a train, followed by re-enable, checks for a quiet output and a first pulse that lands exactly one period after restart. A chain that kept its phase would fire early.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned TAPS  = 5;
  localparam int unsigned IDX_W = $clog2(TAPS);
  localparam int unsigned SEL_W = 3;

  // Clamp an out-of-range code to the last tap, then mirror if requested.
  function automatic logic [IDX_W-1:0] tap_index(input logic [SEL_W-1:0] code,
                                                 input logic reversed);
    logic [IDX_W-1:0] c;
    c = (int'(code) > TAPS - 1) ? IDX_W'(TAPS - 1) : IDX_W'(code);
    return reversed ? IDX_W'(TAPS - 1) - c : c;
  endfunction
endpackage

// File: rtl/refdiv_prog_cnt.sv
module refdiv_prog_cnt #(
  parameter int unsigned RATIO_W   = 10,
  parameter int unsigned MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim = ((ratio < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : ratio) - RATIO_W'(1);
    tick = en && (cnt_q >= lim);
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  resync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (cnt_q == '0));
endmodule

// File: rtl/refdiv_bin_stage.sv
module refdiv_bin_stage #(
  parameter int unsigned TAPS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  output logic [TAPS-1:0] taps
);
  localparam int unsigned BIN_W = TAPS - 1;
  logic [BIN_W-1:0] bin_q, bin_d;

  always_comb begin
    if (!en)       bin_d = '0;
    else if (tick) bin_d = bin_q + BIN_W'(1);
    else           bin_d = bin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_q <= '0;
    else        bin_q <= bin_d;
  end

  assign taps[0] = tick;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign taps[k] = tick & (&bin_q[k-1:0]);
  end

  // R3
  bin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (bin_q == $past(bin_q)));
endmodule

// File: rtl/refdiv_tap_mux.sv
module refdiv_tap_mux
  import refdiv_pkg::*;
#(
  parameter bit REVERSED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TAPS-1:0]  taps,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse_o
);
  logic [IDX_W-1:0] idx;
  logic             pulse_d;

  always_comb begin
    idx     = tap_index(sel, REVERSED);
    pulse_d = en ? taps[idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= pulse_d;
  end

  // R7
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pulse_o);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned RATIO_W   = 10,
  parameter int unsigned MIN_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [SEL_W-1:0]   main_sel,
  input  logic [SEL_W-1:0]   aux_sel,
  output logic               main_pulse,
  output logic               aux_pulse
);
  logic            tick;
  logic [TAPS-1:0] taps;

  refdiv_prog_cnt #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(enable), .ratio(ratio), .tick(tick));

  refdiv_bin_stage #(.TAPS(TAPS)) u_bin (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick), .taps(taps));

  refdiv_tap_mux #(.REVERSED(1'b0)) u_main (
    .clk(clk), .rst_n(rst_n), .en(enable), .taps(taps), .sel(main_sel),
    .pulse_o(main_pulse));

  refdiv_tap_mux #(.REVERSED(1'b1)) u_aux (
    .clk(clk), .rst_n(rst_n), .en(enable), .taps(taps), .sel(aux_sel),
    .pulse_o(aux_pulse));

  logic [IDX_W-1:0] m_idx, a_idx;
  always_comb begin
    m_idx = tap_index(main_sel, 1'b0);
    a_idx = tap_index(aux_sel, 1'b1);
  end

  // R10
  same_tap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(m_idx) == $past(a_idx)) |-> (main_pulse == aux_pulse));
endmodule

// File: tb/sim_refdiv_top.sv
`timescale 1ns/1ps
module sim_refdiv_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [9:0] ratio;
  logic [2:0] main_sel, aux_sel;
  logic       main_pulse, aux_pulse;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  refdiv_top u0 (.clk(clk), .rst_n(rst_n), .enable(enable), .ratio(ratio),
    .main_sel(main_sel), .aux_sel(aux_sel), .main_pulse(main_pulse),
    .aux_pulse(aux_pulse));

  // ratio, main code, aux code, expected main period, expected aux period
  localparam int NV = 10;
  localparam int VEC [NV][5] = '{
    '{10,   0, 4, 10,   10},
    '{5,    1, 3, 10,   10},
    '{4,    2, 0, 16,   64},
    '{3,    0, 0, 4,    64},
    '{0,    4, 1, 64,   32},
    '{6,    7, 5, 96,   6},
    '{7,    3, 6, 56,   7},
    '{12,   2, 2, 48,   48},
    '{1023, 0, 4, 1023, 1023},
    '{9,    6, 7, 144,  9}
  };
  localparam string TAG [NV] = '{"R1 R4 R5 R10", "R3 R4 R5", "R4 R5", "R2",
    "R2 R4 R5", "R6", "R4 R6", "R3", "R1", "R6"};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int cap, output int m1, output int m2,
                         output int a1, output int a2, output bit dbl);
    bit pm, pa;
    m1 = 0; m2 = 0; a1 = 0; a2 = 0; dbl = 0; pm = 0; pa = 0;
    for (int n = 1; n <= cap; n++) begin
      @(posedge clk); #1;
      if (main_pulse) begin if (m1 == 0) m1 = n; else if (m2 == 0) m2 = n; end
      if (aux_pulse)  begin if (a1 == 0) a1 = n; else if (a2 == 0) a2 = n; end
      if ((pm && main_pulse) || (pa && aux_pulse)) dbl = 1;
      pm = main_pulse; pa = aux_pulse;
      if (m2 != 0 && a2 != 0) break;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int m1, m2, a1, a2;
    bit dbl;
    rst_n = 0; enable = 1; ratio = 10'd4; main_sel = 3'd0; aux_sel = 3'd0;
    repeat (6) @(posedge clk);
    #1;
    // R9: outputs held low in reset
    check(!main_pulse && !aux_pulse, "R9 reset quiet", main_pulse, 0);
    @(negedge clk); rst_n = 1;
    measure(200, m1, m2, a1, a2, dbl);
    // R7, R9: first pulse after the 4th enabled edge after release
    check(m1 == 4, "R7 R9 first pulse after reset", m1, 4);
    check(a1 == 64, "R7 aux first pulse after reset", a1, 64);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk); enable = 0;
      ratio = VEC[v][0][9:0]; main_sel = VEC[v][1][2:0]; aux_sel = VEC[v][2][2:0];
      repeat (2) @(negedge clk);
      enable = 1;
      measure(2 * (VEC[v][3] > VEC[v][4] ? VEC[v][3] : VEC[v][4]) + 8, m1, m2, a1, a2, dbl);
      check(m1 == VEC[v][3], {TAG[v], " main first"}, m1, VEC[v][3]);
      check(m2 - m1 == VEC[v][3], {TAG[v], " main period"}, m2 - m1, VEC[v][3]);
      check(a1 == VEC[v][4], {TAG[v], " aux first"}, a1, VEC[v][4]);
      check(a2 - a1 == VEC[v][4], {TAG[v], " aux period"}, a2 - a1, VEC[v][4]);
      check(!dbl, {TAG[v], " R7 single cycle"}, dbl, 0);
    end

    // R8: power-down mid-train, quiet output, then restart from zero phase
    @(negedge clk); enable = 0; ratio = 10'd5; main_sel = 3'd0; aux_sel = 3'd4;
    @(negedge clk); enable = 1;
    repeat (7) @(negedge clk);
    enable = 0;
    begin
      int seen = 0;
      for (int n = 0; n < 40; n++) begin
        @(posedge clk); #1;
        if (main_pulse || aux_pulse) seen++;
      end
      check(seen == 0, "R8 quiet while off", seen, 0);
    end
    @(negedge clk); enable = 1;
    measure(40, m1, m2, a1, a2, dbl);
    check(m1 == 5, "R8 resync main", m1, 5);
    check(a1 == 5, "R8 resync aux", a1, 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule